// File: doc/BRIEF.md
# Two-Stage Prescaler and Linear Clock Divider

The block produces a divided clock from one of several parent clocks. The selected parent first passes through a power-of-two prescaler and then through an integer divider. The output can be switched off with a gate bit. All settings sit in one control register: the linear divisor, the prescale exponent, the parent select and the gate. Software writes this register through a bit mask, so it can change any group of fields without touching the rest, and it can read the whole register back.

The model runs on a single system clock. Each parent clock is given as a stream of one-cycle enable pulses, and the output `div_out` is a level that changes only on a clock edge where the selected parent pulses. New divider and select settings are applied only at the last parent pulse of the current output period, so a period is never cut short. While the gate is off, the output is held low and the period counter is held at zero.

Top module: `mp_clk_div`

## Requirements
- R1: Reset clears the control register to zero. A write replaces the register bits where `reg_wmask` is 1 with `reg_wdata`, keeps every bit where the mask is 0, and `reg_rdata` always shows the whole register.
- R2: With default parameters, the linear field is at bits [3:0], the exponent at bits [17:16], the parent select at bits [25:24] and the gate at bit 31. Writing only these fields leaves all other register bits unchanged.
- R3: With linear field value M and exponent P, the output period is N = (M+1)·2^P pulses of the selected parent, measured from one rising edge of `div_out` to the next.
- R4: For N ≥ 2 the output is high for floor(N/2) parent pulses and low for the rest of the period. `div_out` changes on the clock edge on which the parent pulse is sampled.
- R5: For N = 1 the output follows the selected parent, delayed by one clock. It is high for one cycle after each parent pulse.
- R6: The select field value k routes parent pulse stream k into the divider chain.
- R7: When the gate bit is 0, `clk_on` is 0 and `div_out` is low from the next clock onward. After the gate is set, the output rises on the first selected parent pulse.
- R8: Linear, exponent and select values written while the output runs take effect only after the last pulse of the current period. The period in progress keeps its old length.
- R9: The largest setting, M = 15 and P = 3 with default widths, divides by 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| parent_tick | input | NPAR | One enable pulse per parent clock edge, one bit per parent |
| reg_we | input | 1 | Register write strobe |
| reg_wmask | input | REG_W | Bits to replace on a write |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Current register contents |
| clk_on | output | 1 | Gate bit as currently set |
| div_out | output | 1 | Divided output clock level |

## Verification
The divider is driven with parents that pulse every 2, 3, 4 and 5 system clocks. Each parent's spacing multiplies the expected high time and period by its own factor, so a wrong parent selection shows up as a wrong length. The settings cover an odd total (3), pure prescaling (4), a mixed prescale and linear value (10), unity, two, and the largest divisor. These separate an off-by-one in the stored divisor, a wrong shift amount, and a wrong high-time rule for odd totals. A mid-period rewrite checks that the running period keeps its old length and that the next period uses the new one. A gate-off window checks that the output stays low, and re-enabling checks how quickly the output restarts.

// File: rtl/mpdiv_pkg.sv
package mpdiv_pkg;

  // Total division in parent pulses: linear field stores divisor minus one.
  function automatic logic [31:0] total_div(input logic [31:0] m_field,
                                            input logic [7:0]  p_field);
    logic [31:0] lin;
    lin = m_field + 32'd1;
    return lin << p_field;
  endfunction

  // Pulses spent high within one output period (truncated half).
  function automatic logic [31:0] high_len(input logic [31:0] n_total);
    return n_total >> 1;
  endfunction

endpackage

// File: rtl/mpdiv_ctrl_reg.sv
module mpdiv_ctrl_reg #(
  parameter int REG_W  = 32,
  parameter int M_LSB  = 0,
  parameter int M_W    = 4,
  parameter int P_LSB  = 16,
  parameter int P_W    = 2,
  parameter int S_LSB  = 24,
  parameter int S_W    = 2,
  parameter int G_BIT  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wmask,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [M_W-1:0]   m_field,
  output logic [P_W-1:0]   p_field,
  output logic [S_W-1:0]   s_field,
  output logic             gate_field
);

  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= (ctrl_q & ~wmask) | (wdata & wmask);
    end
  end

  assign rdata      = ctrl_q;
  assign m_field    = ctrl_q[M_LSB +: M_W];
  assign p_field    = ctrl_q[P_LSB +: P_W];
  assign s_field    = ctrl_q[S_LSB +: S_W];
  assign gate_field = ctrl_q[G_BIT];

endmodule

// File: rtl/mpdiv_parent_mux.sv
module mpdiv_parent_mux #(
  parameter int NPAR = 4,
  parameter int S_W  = 2
) (
  input  logic [NPAR-1:0] tick_in,
  input  logic [S_W-1:0]  sel,
  output logic            tick_out
);

  logic [NPAR-1:0] hit;

  for (genvar g = 0; g < NPAR; g++) begin : g_leg
    assign hit[g] = tick_in[g] && (sel == S_W'(g));
  end

  assign tick_out = |hit;

endmodule

// File: rtl/mpdiv_chain.sv
module mpdiv_chain
  import mpdiv_pkg::*;
#(
  parameter int M_W = 4,
  parameter int P_W = 2,
  parameter int S_W = 2,
  localparam int NW    = M_W + (1 << P_W),
  localparam int CFG_W = M_W + P_W + S_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [M_W-1:0]   m_new,
  input  logic [P_W-1:0]   p_new,
  input  logic [S_W-1:0]   s_new,
  input  logic             tick,
  output logic [S_W-1:0]   sel_act,
  output logic [CFG_W-1:0] cfg_act,
  output logic [NW-1:0]    cnt_cur,
  output logic [NW-1:0]    n_cur,
  output logic             term_evt,
  output logic             load_evt,
  output logic             div_out
);

  logic [M_W-1:0] m_a;
  logic [P_W-1:0] p_a;
  logic [S_W-1:0] s_a;
  logic [NW-1:0]  cnt_q;
  logic [NW-1:0]  n_act;
  logic [NW-1:0]  hi_act;
  logic           out_q;

  assign n_act    = NW'(total_div(32'(m_a), 8'(p_a)));
  assign hi_act   = NW'(high_len(32'(n_act)));
  assign term_evt = gate && tick && (cnt_q == n_act - NW'(1));
  assign load_evt = !gate || term_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_a   <= '0;
      p_a   <= '0;
      s_a   <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (load_evt) begin
        m_a <= m_new;
        p_a <= p_new;
        s_a <= s_new;
      end
      if (!gate) begin
        cnt_q <= '0;
        out_q <= 1'b0;
      end else begin
        if (n_act == NW'(1)) begin
          out_q <= tick;
        end else if (tick) begin
          out_q <= (cnt_q < hi_act);
        end
        if (term_evt) begin
          cnt_q <= '0;
        end else if (tick) begin
          cnt_q <= cnt_q + NW'(1);
        end
      end
    end
  end

  assign sel_act = s_a;
  assign cfg_act = {m_a, p_a, s_a};
  assign cnt_cur = cnt_q;
  assign n_cur   = n_act;
  assign div_out = out_q;

endmodule

// File: rtl/mp_clk_div.sv
module mp_clk_div #(
  parameter int NPAR  = 4,
  parameter int REG_W = 32,
  parameter int M_LSB = 0,
  parameter int M_W   = 4,
  parameter int P_LSB = 16,
  parameter int P_W   = 2,
  parameter int S_LSB = 24,
  parameter int S_W   = 2,
  parameter int G_BIT = 31,
  localparam int NW    = M_W + (1 << P_W),
  localparam int CFG_W = M_W + P_W + S_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAR-1:0]  parent_tick,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wmask,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_on,
  output logic             div_out
);

  logic [M_W-1:0]   m_field;
  logic [P_W-1:0]   p_field;
  logic [S_W-1:0]   s_field;
  logic             gate_field;
  logic [S_W-1:0]   sel_act;
  logic             sel_tick;
  logic [CFG_W-1:0] act_cfg;
  logic [NW-1:0]    cnt_cur;
  logic [NW-1:0]    n_cur;
  logic             term_evt;
  logic             load_evt;

  mpdiv_ctrl_reg #(
    .REG_W(REG_W), .M_LSB(M_LSB), .M_W(M_W), .P_LSB(P_LSB), .P_W(P_W),
    .S_LSB(S_LSB), .S_W(S_W), .G_BIT(G_BIT)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wmask(reg_wmask),
    .wdata(reg_wdata), .rdata(reg_rdata), .m_field(m_field),
    .p_field(p_field), .s_field(s_field), .gate_field(gate_field)
  );

  mpdiv_parent_mux #(.NPAR(NPAR), .S_W(S_W)) u_mux (
    .tick_in(parent_tick), .sel(sel_act), .tick_out(sel_tick)
  );

  mpdiv_chain #(.M_W(M_W), .P_W(P_W), .S_W(S_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .gate(gate_field), .m_new(m_field),
    .p_new(p_field), .s_new(s_field), .tick(sel_tick), .sel_act(sel_act),
    .cfg_act(act_cfg), .cnt_cur(cnt_cur), .n_cur(n_cur),
    .term_evt(term_evt), .load_evt(load_evt), .div_out(div_out)
  );

  assign clk_on = gate_field;

endmodule

// File: rtl/mp_clk_div_chk.sv
module mp_clk_div_chk #(
  parameter int REG_W = 32,
  parameter int NW    = 8,
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wmask,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             clk_on,
  input logic             div_out,
  input logic             term_evt,
  input logic             load_evt,
  input logic [NW-1:0]    cnt_cur,
  input logic [NW-1:0]    n_cur,
  input logic [CFG_W-1:0] act_cfg
);

  assert_keep_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ((reg_rdata & ~$past(reg_wmask)) ==
                ($past(reg_rdata) & ~$past(reg_wmask))));

  assert_take_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> ((reg_rdata & $past(reg_wmask)) ==
                ($past(reg_wdata) & $past(reg_wmask))));

  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata));

  assert_gated_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> !div_out);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_cur < n_cur);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> (cnt_cur == '0));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_cfg));

endmodule

bind mp_clk_div mp_clk_div_chk #(.REG_W(REG_W), .NW(NW), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wmask(reg_wmask),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_on(clk_on),
  .div_out(div_out), .term_evt(term_evt), .load_evt(load_evt),
  .cnt_cur(cnt_cur), .n_cur(n_cur), .act_cfg(act_cfg)
);

// File: tb/sim_mp_clk_div.sv
module sim_mp_clk_div;

  localparam int NPAR = 4;
  localparam logic [31:0] CFG_MASK = 32'h8303_000F;
  localparam logic [31:0] SPARE    = 32'h0000_0A00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  parent_tick = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wmask = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_on;
  logic        div_out;

  int checks = 0;
  int errors = 0;

  typedef struct { int hi; int per; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  mp_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .parent_tick(parent_tick), .reg_we(reg_we),
    .reg_wmask(reg_wmask), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_on(clk_on), .div_out(div_out)
  );

  // Parent k pulses once every k+2 system clocks.
  int tc [NPAR];
  initial for (int k = 0; k < NPAR; k++) tc[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < NPAR; k++) begin
      if (tc[k] == k + 1) begin tc[k] = 0; parent_tick[k] = 1'b1; end
      else begin tc[k] = tc[k] + 1; parent_tick[k] = 1'b0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures each output period between rising edges.
  bit prev = 1'b0, run = 1'b0;
  int hcnt = 0, pcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (div_out && !prev) begin
        if (run && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(hcnt == e.hi, {e.tag, " high"}, hcnt, e.hi);
          check(pcnt == e.per, {e.tag, " period"}, pcnt, e.per);
        end
        run = (q.size() > 0);
        hcnt = 0;
        pcnt = 0;
      end
      if (run) begin
        pcnt++;
        if (div_out) hcnt++;
      end
      prev = div_out;
    end
  end

  task automatic wr(input logic [31:0] mask, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_wmask = mask; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] word(input int m, input int p, input int s, input int g);
    return (32'(g) << 31) | (32'(s) << 24) | (32'(p) << 16) | 32'(m);
  endfunction

  task automatic run_cfg(input int m, input int p, input int s, input string tag);
    int n, hi, per;
    exp_t e;
    wr(CFG_MASK, word(m, p, s, 1));
    check(reg_rdata == (word(m, p, s, 1) | SPARE), "R2 fields+spare", int'(reg_rdata),
          int'(word(m, p, s, 1) | SPARE));
    repeat (700) @(negedge clk);
    n   = (m + 1) << p;
    per = n * (s + 2);
    hi  = (n == 1) ? 1 : (n / 2) * (s + 2);
    e.hi = hi; e.per = per; e.tag = tag;
    q.push_back(e);
    q.push_back(e);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reg_rdata == 32'h0, "R1 reset reg", int'(reg_rdata), 0);
    check(div_out == 1'b0, "R7 reset out", int'(div_out), 0);
    check(clk_on == 1'b0, "R7 reset gate", int'(clk_on), 0);
    rst_n = 1'b1;
    wr(32'h0000_00FF, 32'hFFFF_FFFF);
    check(reg_rdata == 32'h0000_00FF, "R1 masked set", int'(reg_rdata), 32'hFF);
    wr(32'h0000_00F0, 32'h0);
    check(reg_rdata == 32'h0000_000F, "R1 masked clear", int'(reg_rdata), 32'h0F);
    wr(32'hFFFF_FFFF, 32'h0);
    wr(32'h0000_0F00, SPARE);
    check(reg_rdata == SPARE, "R1 spare bits", int'(reg_rdata), int'(SPARE));

    run_cfg(2, 0, 0, "R4 odd N=3");
    run_cfg(2, 0, 2, "R6 parent2 N=3");
    run_cfg(0, 2, 1, "R3 prescale N=4");
    run_cfg(4, 1, 3, "R3 mixed N=10");
    run_cfg(0, 0, 1, "R5 unity");
    run_cfg(0, 1, 0, "R4 N=2");
    run_cfg(15, 3, 0, "R9 max N=128");
    run_cfg(7, 0, 0, "R3 N=8");

    // R8: rewrite mid-period; running period keeps 16 clocks, next is 4.
    begin
      int c;
      bit pv;
      while (div_out) @(negedge clk);
      while (!div_out) @(negedge clk);
      c = 0; pv = 1'b1;
      forever begin
        @(negedge clk);
        c++;
        if (c == 3) begin reg_we = 1'b1; reg_wmask = CFG_MASK; reg_wdata = word(1, 0, 0, 1); end
        if (c == 4) reg_we = 1'b0;
        if (div_out && !pv) break;
        pv = div_out;
      end
      check(c == 16, "R8 old period kept", c, 16);
      c = 0; pv = 1'b1;
      forever begin
        @(negedge clk);
        c++;
        if (div_out && !pv) break;
        pv = div_out;
      end
      check(c == 4, "R8 new period", c, 4);
    end

    // R7: gate off holds output low; re-enable restarts on first pulse.
    begin
      int highs, w;
      wr(32'h8000_0000, 32'h0);
      check(clk_on == 1'b0, "R7 gate off", int'(clk_on), 0);
      highs = 0;
      repeat (60) begin
        @(negedge clk);
        if (div_out) highs++;
      end
      check(highs == 0, "R7 low while gated", highs, 0);
      wr(32'h8000_0000, 32'h8000_0000);
      check(clk_on == 1'b1, "R7 gate on", int'(clk_on), 1);
      w = 0;
      while (!div_out && w < 20) begin @(negedge clk); w++; end
      check(w <= 3, "R7 restart delay", w, 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule